// File: doc/BRIEF.md
# Serial EEPROM Bus-Cycle Master

This block sits on the processor side of a single-data-line serial EEPROM that is driven through ordinary chip-enable, output-enable and write-enable strobes. Every bit of a transfer is one complete bus cycle: a write cycle carries one bit into the memory, and a read cycle brings one bit back out. The block accepts a request of one of three kinds: read a run of bytes, write up to one page of bytes, or poll for the end of programming. It expands the request into the chain of single-bit strobe cycles that the memory expects.

Read and write requests open with the resync pattern of read, write-zero, read. A 16-bit address frame follows, most significant bit first. Read bytes are gathered eight cycles each and handed out on a valid/ready port. Write bytes are sent eight cycles each. Programming is then started with read, write-one, read, and the data line is polled until it reads high. Strobe low width, recovery and cycle period are parameters counted in clock ticks. Requests that would cross a page, or that make no sense, are refused before any bus activity.

Top module: `eeprom_cycle_master`

## Requirements
- R1: After reset `ce_n`, `oe_n` and `we_n` are 1, `dq_oe` is 0, `req_ready` is 1 and `done` is 0.
- R2: A read or write request begins with three bus cycles: a read, a write carrying 0, then a read.
- R3: After that opening, the address goes out as 16 write cycles, most significant bit first. The frame is the 9-bit `req_addr` zero-extended to 16 bits, and no read cycle falls inside it.
- R4: A read request of `req_len` bytes takes 8 read cycles per byte, the first bit read being bit 7. Each byte is offered on `rd_data` with `rd_valid`, and it is held stable until `rd_ready`. No bus cycle starts while a byte is waiting.
- R5: A write request sends `req_len` bytes as 8 write cycles each. Byte 0 is `req_wdata[7:0]` and goes first, and each byte is sent bit 7 first.
- R6: After the last data bit, a write request issues read, write carrying 1, read. It then issues read cycles until one samples `dq_in` high, and then pulses `done` for one cycle with both error flags low.
- R7: If `POLL_LIMIT` consecutive poll reads all sample 0, the block stops polling and pulses `done` together with `err_timeout`.
- R8: Some requests are refused with `done` and `err_range` and no strobe activity at all. These are: a write with `req_len` of 0, or with `req_addr[2:0] + req_len` above 8; a read with `req_len` of 0; and `req_op` of 3. Op codes are 0 for read, 1 for write and 2 for poll.
- R9: `oe_n` and `we_n` are never low together, and either one low implies that `ce_n` is low.
- R10: Each strobe stays low for exactly `LOW_TICKS` clocks. From one strobe rising to the next falling there are at least `REC_TICKS` clocks, and between successive falling edges there are at least `CYC_TICKS` clocks.
- R11: `dq_oe` is 1 through every write strobe. It is 0 during every read strobe and in the clock before any read strobe falls.
- R12: A poll request (op 2) issues only read cycles, with no opening pattern and no address, and it ends as in R6 or R7.
- R13: `req_ready` is 1 only when idle. It is 0 in the cycle after a request is accepted, and stays 0 until that request's `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 poll |
| req_addr | input | 9 | Byte address |
| req_len | input | 4 | Byte count |
| req_wdata | input | 64 | Write bytes, byte 0 in bits 7:0 |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle pulse at request end |
| err_range | output | 1 | Request refused, valid with done |
| err_timeout | output | 1 | Polling gave up, valid with done |
| ce_n | output | 1 | Chip enable strobe, active low |
| oe_n | output | 1 | Output enable strobe, active low |
| we_n | output | 1 | Write enable strobe, active low |
| dq_out | output | 1 | Data bit driven toward the memory |
| dq_oe | output | 1 | Drive enable for the data line |
| dq_in | input | 1 | Data bit sampled from the memory |

## Verification
The properties assume that `rd_data` is only claimed stable while `rd_ready` stays low. They also assume that a request is offered only through `req_valid` while `req_ready` is high. The stimulus keeps `req_valid` up for a single accepted cycle, changes inputs a little after the rising edge, and drives `dq_in` only once a read strobe is already low. This gives the data line a full clock of settling before the block samples it at the end of the strobe.

// File: rtl/ecm_pkg.sv
package ecm_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_POLL  = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SYNC,
        PH_ADDR,
        PH_RDAT,
        PH_WDAT,
        PH_FIRE,
        PH_POLL,
        PH_FIN
    } phase_e;

    typedef enum logic [1:0] {
        CY_IDLE,
        CY_SETUP,
        CY_LOW,
        CY_HIGH
    } cyc_st_e;

endpackage

// File: rtl/bit_cycle_engine.sv
module bit_cycle_engine
    import ecm_pkg::*;
#(
    parameter int LOW_TICKS = 3,
    parameter int REC_TICKS = 20,
    parameter int CYC_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_wr,
    input  logic start_bit,
    output logic busy,
    output logic fin,
    output logic rbit,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_out,
    output logic dq_oe,
    input  logic dq_in
);

    localparam int HIGH_TICKS = (CYC_TICKS - LOW_TICKS > REC_TICKS) ? (CYC_TICKS - LOW_TICKS) : REC_TICKS;
    localparam int MAX_TICKS  = (HIGH_TICKS > LOW_TICKS) ? HIGH_TICKS : LOW_TICKS;
    localparam int CNT_W      = $clog2(MAX_TICKS + 1);

    typedef struct packed {
        cyc_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             wr;
        logic             bitv;
        logic             rbit;
    } eng_t;

    eng_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        fin = 1'b0;
        case (s_q.st)
            CY_IDLE: begin
                if (start) begin
                    s_d.st   = CY_SETUP;
                    s_d.cnt  = '0;
                    s_d.wr   = start_wr;
                    s_d.bitv = start_bit;
                end
            end
            CY_SETUP: begin
                s_d.st  = CY_LOW;
                s_d.cnt = '0;
            end
            CY_LOW: begin
                if (s_q.cnt == CNT_W'(LOW_TICKS - 1)) begin
                    if (!s_q.wr) s_d.rbit = dq_in;
                    s_d.st  = CY_HIGH;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: begin
                if (s_q.cnt == CNT_W'(HIGH_TICKS - 1)) begin
                    s_d.st = CY_IDLE;
                    fin    = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = (s_q.st != CY_IDLE);
    assign rbit   = s_q.rbit;
    assign ce_n   = (s_q.st != CY_LOW);
    assign oe_n   = !((s_q.st == CY_LOW) && !s_q.wr);
    assign we_n   = !((s_q.st == CY_LOW) && s_q.wr);
    assign dq_out = s_q.bitv;
    assign dq_oe  = busy && s_q.wr;

endmodule

// File: rtl/page_span_guard.sv
module page_span_guard
    import ecm_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int LEN_W      = 4
) (
    input  logic [1:0]                      op,
    input  logic [$clog2(PAGE_BYTES)-1:0]   page_off,
    input  logic [LEN_W-1:0]                len,
    output logic                            bad
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int SUM_W = ((LEN_W > OFF_W) ? LEN_W : OFF_W) + 1;

    logic [SUM_W-1:0] span_end;

    assign span_end = SUM_W'(page_off) + SUM_W'(len);

    always_comb begin
        bad = 1'b0;
        case (op)
            OP_READ:  bad = (len == '0);
            OP_WRITE: bad = (len == '0) || (span_end > SUM_W'(PAGE_BYTES));
            OP_POLL:  bad = 1'b0;
            default:  bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/eeprom_cycle_master.sv
module eeprom_cycle_master
    import ecm_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int FRAME_W    = 16,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 8,
    parameter int LEN_W      = 4,
    parameter int LOW_TICKS  = 3,
    parameter int REC_TICKS  = 20,
    parameter int CYC_TICKS  = 30,
    parameter int POLL_LIMIT = 10000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [LEN_W-1:0]             req_len,
    input  logic [PAGE_BYTES*DATA_W-1:0] req_wdata,
    output logic                         rd_valid,
    input  logic                         rd_ready,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         done,
    output logic                         err_range,
    output logic                         err_timeout,
    output logic                         ce_n,
    output logic                         oe_n,
    output logic                         we_n,
    output logic                         dq_out,
    output logic                         dq_oe,
    input  logic                         dq_in
);

    localparam int WD_W  = PAGE_BYTES * DATA_W;
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam int BI_W  = $clog2(DATA_W);
    localparam int PC_W  = $clog2(POLL_LIMIT + 1);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] ash;
        logic [WD_W-1:0]    wsh;
        logic [LEN_W-1:0]   left;
        logic [DATA_W-1:0]  sh;
        logic               rvld;
        logic [DATA_W-1:0]  rdat;
        logic [PC_W-1:0]    pcnt;
        logic               is_wr;
        logic               e_rng;
        logic               e_to;
    } top_t;

    top_t q, d;

    logic             eng_start, eng_wr, eng_bit;
    logic             eng_busy, eng_fin, eng_rbit;
    logic             req_bad;
    logic [BI_W-1:0]  bidx;
    logic [DATA_W-1:0] cur_byte;

    page_span_guard #(
        .PAGE_BYTES (PAGE_BYTES),
        .LEN_W      (LEN_W)
    ) u_guard (
        .op       (req_op),
        .page_off (req_addr[OFF_W-1:0]),
        .len      (req_len),
        .bad      (req_bad)
    );

    bit_cycle_engine #(
        .LOW_TICKS (LOW_TICKS),
        .REC_TICKS (REC_TICKS),
        .CYC_TICKS (CYC_TICKS)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (eng_start),
        .start_wr  (eng_wr),
        .start_bit (eng_bit),
        .busy      (eng_busy),
        .fin       (eng_fin),
        .rbit      (eng_rbit),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe),
        .dq_in     (dq_in)
    );

    assign cur_byte = q.wsh[DATA_W-1:0];
    assign bidx     = BI_W'(DATA_W - 1) - q.cnt[BI_W-1:0];

    always_comb begin
        d         = q;
        eng_wr    = 1'b0;
        eng_bit   = 1'b0;
        eng_start = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                d.e_rng = 1'b0;
                d.e_to  = 1'b0;
                if (req_valid) begin
                    d.cnt  = '0;
                    d.pcnt = '0;
                    if (req_bad) begin
                        d.ph    = PH_FIN;
                        d.e_rng = 1'b1;
                    end else if (req_op == OP_POLL) begin
                        d.ph = PH_POLL;
                    end else begin
                        d.ph    = PH_SYNC;
                        d.ash   = FRAME_W'(req_addr);
                        d.wsh   = req_wdata;
                        d.left  = req_len;
                        d.is_wr = (req_op == OP_WRITE);
                    end
                end
            end
            PH_SYNC, PH_FIRE: begin
                eng_wr    = (q.cnt == CNT_W'(1));
                eng_bit   = (q.ph == PH_FIRE);
                eng_start = !eng_busy;
                if (eng_fin) begin
                    if (q.cnt == CNT_W'(2)) begin
                        d.cnt  = '0;
                        d.pcnt = '0;
                        d.ph   = (q.ph == PH_SYNC) ? PH_ADDR : PH_POLL;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_ADDR: begin
                eng_wr    = 1'b1;
                eng_bit   = q.ash[FRAME_W-1];
                eng_start = !eng_busy;
                if (eng_fin) begin
                    d.ash = q.ash << 1;
                    if (q.cnt == CNT_W'(FRAME_W - 1)) begin
                        d.cnt = '0;
                        d.ph  = q.is_wr ? PH_WDAT : PH_RDAT;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_RDAT: begin
                eng_start = !eng_busy && !q.rvld;
                if (eng_fin) begin
                    d.sh = {q.sh[DATA_W-2:0], eng_rbit};
                    if (q.cnt == CNT_W'(DATA_W - 1)) begin
                        d.rvld = 1'b1;
                        d.rdat = {q.sh[DATA_W-2:0], eng_rbit};
                        d.cnt  = '0;
                        d.left = q.left - 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                if (q.rvld && rd_ready) begin
                    d.rvld = 1'b0;
                    if (q.left == '0) d.ph = PH_FIN;
                end
            end
            PH_WDAT: begin
                eng_wr    = 1'b1;
                eng_bit   = cur_byte[bidx];
                eng_start = !eng_busy;
                if (eng_fin) begin
                    if (q.cnt == CNT_W'(DATA_W - 1)) begin
                        d.cnt  = '0;
                        d.wsh  = q.wsh >> DATA_W;
                        d.left = q.left - 1'b1;
                        if (q.left == LEN_W'(1)) d.ph = PH_FIRE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            PH_POLL: begin
                eng_start = !eng_busy;
                if (eng_fin) begin
                    if (eng_rbit) begin
                        d.ph = PH_FIN;
                    end else if (q.pcnt == PC_W'(POLL_LIMIT - 1)) begin
                        d.ph   = PH_FIN;
                        d.e_to = 1'b1;
                    end else begin
                        d.pcnt = q.pcnt + 1'b1;
                    end
                end
            end
            default: begin
                d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready   = (q.ph == PH_IDLE);
    assign rd_valid    = q.rvld;
    assign rd_data     = q.rdat;
    assign done        = (q.ph == PH_FIN);
    assign err_range   = (q.ph == PH_FIN) && q.e_rng;
    assign err_timeout = (q.ph == PH_FIN) && q.e_to;

endmodule

// File: rtl/eeprom_cycle_master_chk.sv
module eeprom_cycle_master_chk #(
    parameter int LOW_TICKS = 3,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              dq_oe,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic              done
);

    logic        strb;
    logic        strb_q;
    logic [15:0] lo_q;

    assign strb = !oe_n || !we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= 1'b0;
            lo_q   <= '0;
        end else begin
            strb_q <= strb;
            lo_q   <= strb ? (lo_q + 16'd1) : 16'd0;
        end
    end

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    a_r9_ce_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !ce_n);

    a_r10_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb && strb_q) |-> (lo_q == 16'(LOW_TICKS)));

    a_r11_quiet_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);

    a_r11_release_early: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !$past(dq_oe));

    a_r11_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> dq_oe);

    a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    a_r13_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind eeprom_cycle_master eeprom_cycle_master_chk #(
    .LOW_TICKS (LOW_TICKS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dq_oe     (dq_oe),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .done      (done)
);

// File: tb/sim_eeprom_cycle_master.sv
module sim_eeprom_cycle_master;

    localparam int CLK_PERIOD = 10;
    localparam int LOW_T      = 2;
    localparam int REC_T      = 3;
    localparam int CYC_T      = 8;
    localparam int PLIM       = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [8:0]  req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [63:0] req_wdata = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        done, err_range, err_timeout;
    logic        ce_n, oe_n, we_n, dq_out, dq_oe;
    logic        dq_in = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    int exp_tok[$];
    int got_tok[$];
    int dq_q[$];
    int got_byte[$];

    bit bp_mode = 1'b0;
    int bp_hold = 0;

    eeprom_cycle_master #(
        .LOW_TICKS  (LOW_T),
        .REC_TICKS  (REC_T),
        .CYC_TICKS  (CYC_T),
        .POLL_LIMIT (PLIM)
    ) u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_op (req_op),
        .req_addr (req_addr), .req_len (req_len), .req_wdata (req_wdata),
        .rd_valid (rd_valid), .rd_ready (rd_ready), .rd_data (rd_data),
        .done (done), .err_range (err_range), .err_timeout (err_timeout),
        .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
        .dq_out (dq_out), .dq_oe (dq_oe), .dq_in (dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Per-clock bus monitor: decodes strobe pulses into tokens
    // 0 = read cycle, 2 = write of 0, 3 = write of 1
    bit p_oe = 1, p_we = 1, p_drv = 0;
    int lo = 0, since_rise = 1000, since_fall = 1000;
    int last_dq = 0;
    int v_r9 = 0, v_r10 = 0, v_r11 = 0, v_r4 = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!oe_n && !we_n) v_r9++;
            if ((!oe_n || !we_n) && ce_n) v_r9++;
            if ((!oe_n && p_oe) || (!we_n && p_we)) begin
                if (since_fall < CYC_T) v_r10++;
                if (since_rise < REC_T) v_r10++;
                if (rd_valid && !rd_ready) v_r4++;
                since_fall = 0;
                if (!oe_n) begin
                    if (dq_oe || p_drv) v_r11++;
                    dq_in = (dq_q.size() > 0) ? dq_q[0][0] : 1'b1;
                end
            end
            if (!we_n && !dq_oe) v_r11++;
            if (!oe_n || !we_n) begin
                lo++;
                last_dq = int'(dq_out);
            end else begin
                since_rise++;
            end
            since_fall++;
            if ((oe_n && !p_oe) || (we_n && !p_we)) begin
                if (lo != LOW_T) v_r10++;
                if (!p_oe) begin
                    got_tok.push_back(0);
                    if (dq_q.size() > 0) void'(dq_q.pop_front());
                    dq_in = 1'b1;
                end else begin
                    got_tok.push_back(2 + last_dq);
                end
                lo = 0;
                since_rise = 0;
            end
            if (rd_valid && rd_ready) got_byte.push_back(int'(rd_data));
            p_oe = oe_n; p_we = we_n; p_drv = dq_oe;
        end
    end

    // read-side consumer, optionally holding off each byte
    always @(posedge clk) begin
        #1;
        if (bp_mode && rd_valid && bp_hold < 5) begin
            rd_ready = 1'b0;
            bp_hold++;
        end else begin
            rd_ready = 1'b1;
            if (rd_valid) bp_hold = 0;
        end
    end

    task automatic add_sync();  exp_tok.push_back(0); exp_tok.push_back(2); exp_tok.push_back(0); endtask
    task automatic add_fire();  exp_tok.push_back(0); exp_tok.push_back(3); exp_tok.push_back(0); endtask
    task automatic add_addr(input int a);
        for (int i = 15; i >= 0; i--) exp_tok.push_back(2 + ((a >> i) & 1));
    endtask
    task automatic add_wbyte(input int b);
        for (int i = 7; i >= 0; i--) exp_tok.push_back(2 + ((b >> i) & 1));
    endtask
    task automatic add_reads(input int n);
        for (int i = 0; i < n; i++) exp_tok.push_back(0);
    endtask
    task automatic add_dq_byte(input int b);
        for (int i = 7; i >= 0; i--) dq_q.push_back((b >> i) & 1);
    endtask

    task automatic run_req(input int op, input int addr, input int len, input logic [63:0] wd,
                           input bit exp_rng, input bit exp_to, input bit hdr, input string tg);
        int waited;
        bit seen;
        got_tok.delete();
        got_byte.delete();
        @(posedge clk); #1;
        req_op = op[1:0]; req_addr = addr[8:0]; req_len = len[3:0]; req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b0, "R13", int'(req_ready), 0);
        waited = 0;
        seen = 0;
        while (!seen && waited < 20000) begin
            if (done) begin
                seen = 1;
                check(err_range == exp_rng, "R8", int'(err_range), int'(exp_rng));
                check(err_timeout == exp_to, "R7", int'(err_timeout), int'(exp_to));
            end else begin
                @(negedge clk);
                waited++;
            end
        end
        check(seen, "R6", int'(seen), 1);
        @(negedge clk);
        check(req_ready == 1'b1, "R13", int'(req_ready), 1);
        check(got_tok.size() == exp_tok.size(), tg, got_tok.size(), exp_tok.size());
        for (int i = 0; i < exp_tok.size() && i < got_tok.size(); i++)
            check(got_tok[i] == exp_tok[i], (hdr && i < 3) ? "R2" : ((hdr && i < 19) ? "R3" : tg),
                  got_tok[i], exp_tok[i]);
        exp_tok.delete();
        dq_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(ce_n && oe_n && we_n, "R1", int'({ce_n, oe_n, we_n}), 7);
        check(!dq_oe, "R1", int'(dq_oe), 0);
        check(req_ready && !done, "R1", int'({req_ready, done}), 2);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R4 read three bytes from 0x1A5
        add_sync(); add_addr('h1A5); add_reads(24);
        dq_q.push_back(1); dq_q.push_back(1);
        add_dq_byte('hA5); add_dq_byte('h3C); add_dq_byte('hF0);
        run_req(0, 'h1A5, 3, '0, 0, 0, 1, "R4");
        check(got_byte.size() == 3, "R4", got_byte.size(), 3);
        if (got_byte.size() == 3) begin
            check(got_byte[0] == 'hA5, "R4", got_byte[0], 'hA5);
            check(got_byte[1] == 'h3C, "R4", got_byte[1], 'h3C);
            check(got_byte[2] == 'hF0, "R4", got_byte[2], 'hF0);
        end

        // R4 read with consumer back-pressure at top address
        bp_mode = 1'b1;
        add_sync(); add_addr('h1FF); add_reads(16);
        dq_q.push_back(1); dq_q.push_back(1);
        add_dq_byte('h81); add_dq_byte('h7E);
        run_req(0, 'h1FF, 2, '0, 0, 0, 1, "R4");
        bp_mode = 1'b0;
        check(got_byte.size() == 2, "R4", got_byte.size(), 2);
        if (got_byte.size() == 2) begin
            check(got_byte[0] == 'h81, "R4", got_byte[0], 'h81);
            check(got_byte[1] == 'h7E, "R4", got_byte[1], 'h7E);
        end

        // R5 R6 full aligned page, two busy polls
        add_sync(); add_addr('h010);
        for (int b = 0; b < 8; b++) add_wbyte(8'h11 * b + 8'h0F);
        add_fire(); add_reads(3);
        dq_q = '{1, 1, 1, 1, 0, 0, 1};
        run_req(1, 'h010, 8, {8'h86, 8'h75, 8'h64, 8'h53, 8'h42, 8'h31, 8'h20, 8'h0F}, 0, 0, 1, "R5");

        // R5 short write ending on the last byte of a page, ready at once
        add_sync(); add_addr('h00D);
        add_wbyte('hC3); add_wbyte('h5A); add_wbyte('h01);
        add_fire(); add_reads(1);
        dq_q = '{1, 1, 1, 1, 1};
        run_req(1, 'h00D, 3, {40'h0, 8'h01, 8'h5A, 8'hC3}, 0, 0, 1, "R6");

        // R8 refusals: page crossing, zero lengths, reserved op
        run_req(1, 'h00E, 3, '0, 1, 0, 0, "R8");
        run_req(1, 'h020, 0, '0, 1, 0, 0, "R8");
        run_req(1, 'h020, 9, '0, 1, 0, 0, "R8");
        run_req(0, 'h020, 0, '0, 1, 0, 0, "R8");
        run_req(3, 'h020, 1, '0, 1, 0, 0, "R8");

        // R12 bare poll, three busy reads then ready
        add_reads(4);
        dq_q = '{0, 0, 0, 1};
        run_req(2, 0, 0, '0, 0, 0, 0, "R12");

        // R7 bare poll that never sees ready
        add_reads(PLIM);
        for (int i = 0; i < PLIM; i++) dq_q.push_back(0);
        run_req(2, 0, 0, '0, 0, 1, 0, "R7");

        // R7 write whose programming never finishes
        add_sync(); add_addr('h1F8); add_wbyte('h96); add_fire(); add_reads(PLIM);
        dq_q = '{1, 1, 1, 1};
        for (int i = 0; i < PLIM; i++) dq_q.push_back(0);
        run_req(1, 'h1F8, 1, 64'h96, 0, 1, 1, "R7");

        // protocol-wide observations
        check(v_r9 == 0, "R9", v_r9, 0);
        check(v_r10 == 0, "R10", v_r10, 0);
        check(v_r11 == 0, "R11", v_r11, 0);
        check(v_r4 == 0, "R4", v_r4, 0);
        finish_run();
    end

endmodule